// File: doc/BRIEF.md
# Power-On Reset Stretcher with Cascaded Reset Tree

This block turns one asynchronous power-on reset into three active-low reset outputs arranged as a strict chain: a power-on domain at the root, a lifecycle domain below it and a system domain below that. The power-on output is held asserted until the always-on power-good input has been high for an unbroken run of clock cycles. The run length is set by the parameter `STABLE_CYCLES`, which defaults to 32. Test logic can force the whole tree into reset with a scan reset input. That input only acts while scan mode is enabled.

Once the root is released, a power controller can put the lifecycle or system domain back into reset with its request inputs. A debug reset request also resets the system domain. Each reset output has an active-high enable companion that other logic can use.

The stretcher is a three-state machine. In `STR_HOLD`, power-good is low or the root has just been reset. `STR_HOLD` moves to `STR_COUNT` on the first cycle power-good is high. `STR_COUNT` returns to `STR_HOLD` whenever power-good drops. `STR_COUNT` moves to `STR_DONE` when the run is complete. `STR_DONE`, the only state that releases the power-on output, falls back to `STR_HOLD` if power-good is lost. Any assertion of the power-on input, or a scan reset while scan mode is on, forces `STR_HOLD` asynchronously.

Top module: `rst_cascade_ctrl`

## Requirements
- R1: After the root reset is released, `rst_por_n` rises on the clock edge that completes `STABLE_CYCLES` (32) consecutive edges with `pwr_good` high, and not earlier.
- R2: A low cycle on `pwr_good`, or an assertion of `por_n`, before the run is complete restarts the full 32-cycle count.
- R3: While `scan_mode` is 1, a low `scan_rst_n` asserts all three reset outputs at once, without waiting for a clock edge.
- R4: The tree is a strict cascade: when `rst_por_n` is low, `rst_lc_n` is low; when `rst_lc_n` is low, `rst_sys_n` is low.
- R5: When `lc_req` is high at a clock edge, `rst_lc_n` is low after that edge. When `sys_req` is high at a clock edge, `rst_sys_n` is low after that edge. A system request leaves `rst_lc_n` unchanged.
- R6: When `dbg_req` is high at a clock edge, `rst_sys_n` is low after that edge, and `rst_lc_n` is unaffected.
- R7: `rst_en` is active high. Bit 0 pairs with `rst_por_n`, bit 1 with `rst_lc_n` and bit 2 with `rst_sys_n`. Each bit is 1 exactly while its reset is low.
- R8: Release runs from parent to child, one clock apart: `rst_lc_n` rises one edge after `rst_por_n` has risen, and `rst_sys_n` rises one edge after `rst_lc_n` has risen. Each release also requires that domain's request inputs to be low.
- R9: If `pwr_good` falls after `rst_por_n` has been released, `rst_por_n` is asserted at the next clock edge, and a fresh 32-cycle run is needed to release it again.
- R10: While `scan_mode` is 0, `scan_rst_n` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pwr_good | input | 1 | Always-on power-good indication |
| scan_mode | input | 1 | Scan mode enable; qualifies scan_rst_n |
| scan_rst_n | input | 1 | Scan reset, active low |
| lc_req | input | 1 | Lifecycle reset request from the power controller |
| sys_req | input | 1 | System reset request from the power controller |
| dbg_req | input | 1 | Debug reset request for the system domain |
| rst_por_n | output | 1 | Stretched power-on domain reset, active low |
| rst_lc_n | output | 1 | Lifecycle domain reset, active low |
| rst_sys_n | output | 1 | System domain reset, active low |
| rst_en | output | 3 | Reset-enable bits {sys, lc, por}, active high |

## Verification
A stretcher state machine that is off by one shows up as `rst_por_n` rising one edge early or late relative to the run of `pwr_good`. That is why the bench samples on the 31st and 32nd edges, after both a clean start and an interrupted run. A stage flop that captures the wrong request, or that is wired to the wrong parent, breaks the cascade at once. It shows as a child reset that is high while its parent is low, or as a request that fails to assert its domain within one edge. Errors on the scan-qualification path show without any clock, as soon as `scan_rst_n` changes.

// File: rtl/rst_cascade_pkg.sv
package rst_cascade_pkg;

    typedef enum logic [1:0] {
        STR_HOLD  = 2'd0,
        STR_COUNT = 2'd1,
        STR_DONE  = 2'd2
    } stretch_state_e;

    localparam int unsigned NUM_DOMAINS = 3;

endpackage

// File: rtl/rst_root_gate.sv
module rst_root_gate (
    input  logic por_n,
    input  logic scan_mode,
    input  logic scan_rst_n,
    output logic root_n
);
    // Scan reset acts only when qualified by scan mode.
    always_comb begin
        root_n = por_n & (scan_rst_n | ~scan_mode);
    end
endmodule

// File: rtl/rst_stretcher.sv
module rst_stretcher
    import rst_cascade_pkg::*;
#(
    parameter int unsigned STABLE_CYCLES = 32
) (
    input  logic clk,
    input  logic root_n,
    input  logic pwr_good,
    output logic por_out_n
);
    localparam int unsigned CNT_W = $clog2(STABLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    stretch_state_e   state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge root_n) begin
        if (!root_n) begin
            state_q <= STR_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            STR_HOLD: begin
                cnt_d = '0;
                if (pwr_good) begin
                    cnt_d   = ONE;
                    state_d = (STABLE_CYCLES == 1) ? STR_DONE : STR_COUNT;
                end
            end
            STR_COUNT: begin
                if (!pwr_good) begin
                    state_d = STR_HOLD;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = STR_DONE;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            STR_DONE: begin
                if (!pwr_good) begin
                    state_d = STR_HOLD;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = STR_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    // Output logic
    always_comb begin
        por_out_n = (state_q == STR_DONE);
    end
endmodule

// File: rtl/rst_stage.sv
module rst_stage (
    input  logic clk,
    input  logic parent_n,
    input  logic req,
    output logic child_n
);
    // Asynchronous assert from the parent, release one edge later.
    always_ff @(posedge clk or negedge parent_n) begin
        if (!parent_n) begin
            child_n <= 1'b0;
        end else begin
            child_n <= ~req;
        end
    end
endmodule

// File: rtl/rst_cascade_ctrl.sv
module rst_cascade_ctrl
    import rst_cascade_pkg::*;
#(
    parameter int unsigned STABLE_CYCLES = 32
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       pwr_good,
    input  logic       scan_mode,
    input  logic       scan_rst_n,
    input  logic       lc_req,
    input  logic       sys_req,
    input  logic       dbg_req,
    output logic       rst_por_n,
    output logic       rst_lc_n,
    output logic       rst_sys_n,
    output logic [2:0] rst_en
);
    logic                   root_n;
    logic [NUM_DOMAINS-1:0] dom_n;
    logic [NUM_DOMAINS-1:0] dom_req;

    rst_root_gate u_root (
        .por_n      (por_n),
        .scan_mode  (scan_mode),
        .scan_rst_n (scan_rst_n),
        .root_n     (root_n)
    );

    rst_stretcher #(.STABLE_CYCLES(STABLE_CYCLES)) u_stretch (
        .clk       (clk),
        .root_n    (root_n),
        .pwr_good  (pwr_good),
        .por_out_n (dom_n[0])
    );

    assign dom_req = {sys_req | dbg_req, lc_req, 1'b0};

    for (genvar gi = 1; gi < NUM_DOMAINS; gi++) begin : g_stage
        rst_stage u_stage (
            .clk      (clk),
            .parent_n (dom_n[gi-1]),
            .req      (dom_req[gi]),
            .child_n  (dom_n[gi])
        );
    end

    for (genvar gj = 0; gj < NUM_DOMAINS; gj++) begin : g_en
        assign rst_en[gj] = ~dom_n[gj];
    end

    assign rst_por_n = dom_n[0];
    assign rst_lc_n  = dom_n[1];
    assign rst_sys_n = dom_n[2];
endmodule

// File: rtl/rst_cascade_checker.sv
module rst_cascade_checker #(
    parameter int unsigned STABLE_CYCLES = 32
) (
    input logic clk,
    input logic por_n,
    input logic pwr_good,
    input logic scan_mode,
    input logic scan_rst_n,
    input logic lc_req,
    input logic sys_req,
    input logic dbg_req,
    input logic rst_por_n,
    input logic rst_lc_n,
    input logic rst_sys_n
);
    localparam int unsigned RUN_W = $clog2(STABLE_CYCLES + 2);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STABLE_CYCLES + 1);

    logic             chk_root_n;
    logic [RUN_W-1:0] run_q;

    assign chk_root_n = por_n & ~(scan_mode & ~scan_rst_n);

    // Independent count of consecutive power-good edges.
    always_ff @(posedge clk or negedge chk_root_n) begin
        if (!chk_root_n) begin
            run_q <= '0;
        end else if (!pwr_good) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    AST_STRETCH_RUN: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_por_n) |-> (run_q >= RUN_W'(STABLE_CYCLES))); // R1
    AST_CASCADE_LC: assert property (@(posedge clk) disable iff (!por_n)
        !rst_por_n |-> !rst_lc_n); // R4
    AST_CASCADE_SYS: assert property (@(posedge clk) disable iff (!por_n)
        !rst_lc_n |-> !rst_sys_n); // R4
    AST_SCAN_FORCE: assert property (@(posedge clk) disable iff (!por_n)
        (scan_mode && !scan_rst_n) |-> (!rst_por_n && !rst_lc_n && !rst_sys_n)); // R3
    AST_LC_REQ: assert property (@(posedge clk) disable iff (!por_n)
        lc_req |=> !rst_lc_n); // R5
    AST_SYS_REQ: assert property (@(posedge clk) disable iff (!por_n)
        sys_req |=> !rst_sys_n); // R5
    AST_DBG_REQ: assert property (@(posedge clk) disable iff (!por_n)
        dbg_req |=> !rst_sys_n); // R6
    AST_ORDER_LC: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_lc_n) |-> $past(rst_por_n)); // R8
    AST_ORDER_SYS: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_sys_n) |-> $past(rst_lc_n)); // R8
    AST_PG_LOSS: assert property (@(posedge clk) disable iff (!por_n)
        (rst_por_n && !pwr_good) |=> !rst_por_n); // R9
endmodule

bind rst_cascade_ctrl rst_cascade_checker #(.STABLE_CYCLES(STABLE_CYCLES)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .pwr_good   (pwr_good),
    .scan_mode  (scan_mode),
    .scan_rst_n (scan_rst_n),
    .lc_req     (lc_req),
    .sys_req    (sys_req),
    .dbg_req    (dbg_req),
    .rst_por_n  (rst_por_n),
    .rst_lc_n   (rst_lc_n),
    .rst_sys_n  (rst_sys_n)
);

// File: tb/rst_cascade_ctrl_tb.sv
`timescale 1ns/1ps
module rst_cascade_ctrl_tb;
    logic       clk = 1'b0;
    logic       por_n, pwr_good, scan_mode, scan_rst_n;
    logic       lc_req, sys_req, dbg_req;
    logic       rst_por_n, rst_lc_n, rst_sys_n;
    logic [2:0] rst_en;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    rst_cascade_ctrl u_dut (
        .clk(clk), .por_n(por_n), .pwr_good(pwr_good), .scan_mode(scan_mode),
        .scan_rst_n(scan_rst_n), .lc_req(lc_req), .sys_req(sys_req), .dbg_req(dbg_req),
        .rst_por_n(rst_por_n), .rst_lc_n(rst_lc_n), .rst_sys_n(rst_sys_n), .rst_en(rst_en)
    );

    // Vector: {lc_req, sys_req, dbg_req, exp_por, exp_lc, exp_sys}
    localparam logic [5:0] VECS [8] = '{
        6'b000_111, 6'b100_100, 6'b000_111, 6'b010_110,
        6'b001_110, 6'b011_110, 6'b110_100, 6'b000_111
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [5:0] got, input logic [5:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {rst_por_n, rst_lc_n, rst_sys_n, rst_en};
    endfunction

    function automatic logic [5:0] want(input logic [2:0] r);
        return {r, ~r[0], ~r[1], ~r[2]};
    endfunction

    initial begin
        por_n = 1'b0; pwr_good = 1'b0; scan_mode = 1'b0; scan_rst_n = 1'b1;
        lc_req = 1'b0; sys_req = 1'b0; dbg_req = 1'b0;
        tick(3);
        chk("R4 R7 reset state", outs(), want(3'b000));

        // R1: release after 32 stable edges, then R8 ordering
        por_n = 1'b1; pwr_good = 1'b1;
        tick(31);
        chk("R1 held at edge 31", outs(), want(3'b000));
        tick(1);
        chk("R1 R8 released at edge 32", outs(), want(3'b100));
        tick(1);
        chk("R8 lc one edge later", outs(), want(3'b110));
        tick(1);
        chk("R8 R7 sys one edge later", outs(), want(3'b111));

        // R5 R6 R4: request table
        for (int i = 0; i < 8; i++) begin
            {lc_req, sys_req, dbg_req} = VECS[i][5:3];
            tick(2);
            chk($sformatf("R5 R6 R4 vector %0d", i), outs(), want(VECS[i][2:0]));
        end

        // R9: loss of power-good after release
        pwr_good = 1'b0;
        tick(1);
        chk("R9 por reasserted", outs(), want(3'b000));
        // R2: interrupted run restarts
        pwr_good = 1'b1;
        tick(20);
        pwr_good = 1'b0;
        tick(1);
        pwr_good = 1'b1;
        tick(31);
        chk("R2 pwr_good drop restarts count", outs(), want(3'b000));
        tick(1);
        chk("R2 release after full run", outs(), want(3'b100));
        tick(2);

        // R2: por_n pulse during count
        por_n = 1'b0;
        #1;
        chk("R2 por_n async assert", outs(), want(3'b000));
        por_n = 1'b1;
        tick(20);
        por_n = 1'b0;
        #1;
        por_n = 1'b1;
        tick(31);
        chk("R2 por_n pulse restarts count", outs(), want(3'b000));
        tick(1);
        chk("R2 release after por pulse", outs(), want(3'b100));
        tick(2);
        chk("R8 tree released", outs(), want(3'b111));

        // R10: scan reset ignored outside scan mode
        scan_rst_n = 1'b0;
        tick(2);
        chk("R10 scan reset ignored", outs(), want(3'b111));
        scan_rst_n = 1'b1;

        // R3: qualified scan reset forces the tree asynchronously
        scan_mode = 1'b1;
        scan_rst_n = 1'b0;
        #1;
        chk("R3 scan reset forces all", outs(), want(3'b000));
        scan_rst_n = 1'b1;
        scan_mode = 1'b0;
        tick(32);
        chk("R3 R1 recovery after scan", outs(), want(3'b100));
        tick(2);
        chk("R3 tree released after scan", outs(), want(3'b111));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule